// File: doc/BRIEF.md
# Display controller power-up sequencer

This block brings a TFT display controller out of power-up without help from software. A start pulse latches a resolution code. The block pulses the panel's hardware reset line. It then walks a fixed list of nineteen register writes, with the values chosen by the latched resolution. Each write is handed to a separate register-write framer over a simple request/acknowledge pair. The framer owns all serial framing.

Between some writes the block pauses for a whole number of milliseconds. The pauses let the clock synthesizer lock, the pixel clock settle, the backlight PWM start and the panel turn on. The millisecond time base comes from a clock-cycles-per-millisecond parameter, so a testbench can shrink every wait.

When the list is finished the block raises a done flag. A resolution code it does not know raises an error flag at once, without any write and without any reset pulse.

Top module: `lcd_bringup_seq`

## Requirements
- R1: While and after `rstN` is low, `busy`, `done`, `error` and `wrReq` are low and `panelRstN` is high.
- R2: `modeSel` codes are 0 = 320x240, 1 = 480x272, 2 = 640x480 and 3 = 800x480; codes 4 to 7 are unsupported. A start in idle with an unsupported code sets `error` in the next cycle. `busy` stays low, `wrReq` never rises and `panelRstN` stays high.
- R3: A start in idle with a supported code raises `busy` in the next cycle. `busy` stays high until the run ends, and `wrReq` is only ever high while `busy` is high.
- R4: A start while `busy` is high is ignored. The code on `modeSel` is latched at the accepted start, so later changes to it do not alter the running list.
- R5: `panelRstN` goes low in the cycle after an accepted start and stays low for exactly RST_MS*CYC_PER_MS cycles. The first request appears in the cycle it returns high, and no request is made while it is low.
- R6: A write completes at a rising edge where `wrReq` and `wrAck` are both high. While `wrReq` is high and `wrAck` is low, `wrReq`, `wrAddr` and `wrData` hold their values.
- R7: Exactly 19 writes go out, with addresses in this order: 0x88, 0x89, 0x10, 0x04, 0x14 up to 0x1F ascending, 0x8A, 0x8B, 0x01.
- R8: The following values are the same in every mode or set by mode pair. 0x88 gets 0x0A in modes 0 and 1 and 0x0B in modes 2 and 3. 0x89 gets 0x02, 0x10 gets 0x0C, 0x8A gets 0x81, 0x8B gets 0xFF and 0x01 gets 0x80.
- R9: Register 0x04 (pixel clock) gets 0x03, 0x82, 0x01, 0x81 in modes 0, 1, 2, 3.
- R10: Registers 0x14..0x1F receive, in address order, one value set per mode:
  - mode 0: 27 00 05 04 03 EF 00 05 00 0E 00 02
  - mode 1: 3B 00 01 00 05 0F 01 02 00 07 00 09
  - mode 2: 4F 05 0F 01 00 DF 01 0A 00 0E 00 01
  - mode 3: 63 03 03 02 00 DF 01 14 00 06 00 01
- R11: `wrReq` stays low for exactly 10*CYC_PER_MS cycles after the write to 0x89 completes, and for 1*CYC_PER_MS cycles after the write to 0x04. The same 10*CYC_PER_MS gap follows the write to 0x8B. After every other write except the last, the next request is presented in the following cycle.
- R12: Exactly 10*CYC_PER_MS cycles after the 0x01 write completes, `done` rises and `busy` falls in the same cycle. `done` and `error` then hold until the next start in idle, which clears both, and neither is high while `busy` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin the sequence |
| modeSel | input | MODE_W | Resolution code, sampled at an accepted start |
| panelRstN | output | 1 | Active-low hardware reset to the display |
| wrReq | output | 1 | Register write request to the framer |
| wrAddr | output | 8 | Register address of the pending write |
| wrData | output | 8 | Register value of the pending write |
| wrAck | input | 1 | Framer acknowledge; completes the pending write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished normally (held) |
| error | output | 1 | Unsupported resolution requested (held) |

## Verification
A step index that skips or repeats shows up at once as a wrong address or value on the first request after the bad advance. The bench compares every write against the expected list, so such a fault is caught on that write. A timer loaded with the wrong length, or a prescaler that is off by one, stretches or shortens the low stretch of `wrReq` or `panelRstN` by whole cycles. Those stretches are measured exactly, so the fault appears within the very pause that is affected. A latched mode register that follows `modeSel` during a run corrupts the next mode-dependent value, and a start that is not blocked while busy restarts the reset pulse; both become visible within a few cycles of the disturbance.

// File: rtl/lcd_bringup_pkg.sv
package lcd_bringup_pkg;

  localparam int STEP_COUNT = 19;
  localparam int IDX_W      = $clog2(STEP_COUNT);
  localparam int MODE_COUNT = 4;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RST,
    ST_REQ,
    ST_PAUSE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armRun;       // latch mode, clear step index
    logic loadRstWait;  // load timer with panel reset length
    logic loadStepWait; // load timer with pause of current step
    logic stepNext;     // advance step index
    logic tickRun;      // let the timer count
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic modeOk;
    logic waitDone;
    logic stepPauses;
    logic lastStep;
  } seqStatus_t;

endpackage

// File: rtl/lcd_bringup_dp.sv
module lcd_bringup_dp
  import lcd_bringup_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int RST_MS     = 1,
  parameter int LONG_MS    = 10,
  parameter int SHORT_MS   = 1,
  parameter int MODE_W     = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MODE_W-1:0]   modeSel,
  input  seqStrobe_t          stb,
  output seqStatus_t          sts,
  output logic [BYTE_W-1:0]   wrAddr,
  output logic [BYTE_W-1:0]   wrData
);

  localparam int MS_MAX = (RST_MS > LONG_MS) ? ((RST_MS > SHORT_MS) ? RST_MS : SHORT_MS)
                                             : ((LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS);
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam int PRE_W  = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;

  // panel timing bytes for registers 0x14..0x1F, entry 0 first
  localparam logic [0:11][7:0] TIM_M0 = '{8'h27, 8'h00, 8'h05, 8'h04, 8'h03, 8'hEF,
                                          8'h00, 8'h05, 8'h00, 8'h0E, 8'h00, 8'h02};
  localparam logic [0:11][7:0] TIM_M1 = '{8'h3B, 8'h00, 8'h01, 8'h00, 8'h05, 8'h0F,
                                          8'h01, 8'h02, 8'h00, 8'h07, 8'h00, 8'h09};
  localparam logic [0:11][7:0] TIM_M2 = '{8'h4F, 8'h05, 8'h0F, 8'h01, 8'h00, 8'hDF,
                                          8'h01, 8'h0A, 8'h00, 8'h0E, 8'h00, 8'h01};
  localparam logic [0:11][7:0] TIM_M3 = '{8'h63, 8'h03, 8'h03, 8'h02, 8'h00, 8'hDF,
                                          8'h01, 8'h14, 8'h00, 8'h06, 8'h00, 8'h01};

  logic [1:0]       modeReg;
  logic [IDX_W-1:0] stepIdx;
  logic [MS_W-1:0]  msLeft;
  logic [MS_W-1:0]  stepMs;
  logic             msTick;
  logic [3:0]       timIdx;

  // mode latch and step index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      stepIdx <= '0;
    end else if (stb.armRun) begin
      modeReg <= modeSel[1:0];
      stepIdx <= '0;
    end else if (stb.stepNext) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  // millisecond prescaler, dropped when one cycle already is a millisecond
  generate
    if (CYC_PER_MS == 1) begin : gNoPre
      assign msTick = 1'b1;
    end else begin : gPre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN)
          preCnt <= '0;
        else if (stb.loadRstWait || stb.loadStepWait)
          preCnt <= '0;
        else if (stb.tickRun)
          preCnt <= msTick ? '0 : preCnt + 1'b1;
      end
      assign msTick = (preCnt == PRE_W'(CYC_PER_MS - 1));
    end
  endgenerate

  // pause length belonging to each step
  always_comb begin
    case (stepIdx)
      IDX_W'(1), IDX_W'(17), IDX_W'(18): stepMs = MS_W'(LONG_MS);
      IDX_W'(3):                         stepMs = MS_W'(SHORT_MS);
      default:                           stepMs = '0;
    endcase
  end

  // millisecond down counter
  always_ff @(posedge clk) begin
    if (!rstN)
      msLeft <= '0;
    else if (stb.loadRstWait)
      msLeft <= MS_W'(RST_MS);
    else if (stb.loadStepWait)
      msLeft <= stepMs;
    else if (stb.tickRun && msTick && (msLeft != '0))
      msLeft <= msLeft - 1'b1;
  end

  assign sts.modeOk     = (int'(modeSel) < MODE_COUNT);
  assign sts.waitDone   = msTick && (msLeft == MS_W'(1));
  assign sts.stepPauses = (stepMs != '0);
  assign sts.lastStep   = (stepIdx == IDX_W'(STEP_COUNT - 1));

  // register address of the current step
  always_comb begin
    case (stepIdx)
      IDX_W'(0):  wrAddr = 8'h88;
      IDX_W'(1):  wrAddr = 8'h89;
      IDX_W'(2):  wrAddr = 8'h10;
      IDX_W'(3):  wrAddr = 8'h04;
      IDX_W'(16): wrAddr = 8'h8A;
      IDX_W'(17): wrAddr = 8'h8B;
      IDX_W'(18): wrAddr = 8'h01;
      default:    wrAddr = 8'h10 + 8'(stepIdx);
    endcase
  end

  assign timIdx = 4'(stepIdx - IDX_W'(4));

  // register value of the current step
  always_comb begin
    case (stepIdx)
      IDX_W'(0):  wrData = modeReg[1] ? 8'h0B : 8'h0A;
      IDX_W'(1):  wrData = 8'h02;
      IDX_W'(2):  wrData = 8'h0C;
      IDX_W'(3): begin
        case (modeReg)
          2'd0:    wrData = 8'h03;
          2'd1:    wrData = 8'h82;
          2'd2:    wrData = 8'h01;
          default: wrData = 8'h81;
        endcase
      end
      IDX_W'(16): wrData = 8'h81;
      IDX_W'(17): wrData = 8'hFF;
      IDX_W'(18): wrData = 8'h80;
      default: begin
        if (timIdx > 4'd11)
          wrData = 8'h00;
        else begin
          case (modeReg)
            2'd0:    wrData = TIM_M0[timIdx];
            2'd1:    wrData = TIM_M1[timIdx];
            2'd2:    wrData = TIM_M2[timIdx];
            default: wrData = TIM_M3[timIdx];
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/lcd_bringup_ctrl.sv
module lcd_bringup_ctrl
  import lcd_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrAck,
  input  seqStatus_t sts,
  output seqStrobe_t stb,
  output logic       panelRstN,
  output logic       wrReq,
  output logic       busy,
  output logic       done,
  output logic       error
);

  seqState_t state, stateNxt;
  logic      finishNow;
  logic      startIdle;

  assign startIdle = (state == ST_IDLE) && start;
  assign finishNow = (state == ST_PAUSE) && sts.waitDone && sts.lastStep;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    case (state)
      ST_IDLE: begin
        if (start && sts.modeOk) begin
          stateNxt        = ST_RST;
          stb.armRun      = 1'b1;
          stb.loadRstWait = 1'b1;
        end
      end
      ST_RST: begin
        stb.tickRun = 1'b1;
        if (sts.waitDone) stateNxt = ST_REQ;
      end
      ST_REQ: begin
        if (wrAck) begin
          if (sts.stepPauses) begin
            stateNxt         = ST_PAUSE;
            stb.loadStepWait = 1'b1;
          end else begin
            stb.stepNext = 1'b1;
          end
        end
      end
      ST_PAUSE: begin
        stb.tickRun = 1'b1;
        if (sts.waitDone) begin
          if (sts.lastStep) begin
            stateNxt = ST_IDLE;
          end else begin
            stateNxt     = ST_REQ;
            stb.stepNext = 1'b1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startIdle) begin
        done  <= 1'b0;
        error <= !sts.modeOk;
      end else if (finishNow) begin
        done <= 1'b1;
      end
    end
  end

  assign panelRstN = (state != ST_RST);
  assign wrReq     = (state == ST_REQ);
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/lcd_bringup_seq.sv
module lcd_bringup_seq
  import lcd_bringup_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int RST_MS     = 1,
  parameter int LONG_MS    = 10,
  parameter int SHORT_MS   = 1,
  parameter int MODE_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] modeSel,
  output logic              panelRstN,
  output logic              wrReq,
  output logic [7:0]        wrAddr,
  output logic [7:0]        wrData,
  input  logic              wrAck,
  output logic              busy,
  output logic              done,
  output logic              error
);

  seqStrobe_t stb;
  seqStatus_t sts;

  lcd_bringup_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wrAck     (wrAck),
    .sts       (sts),
    .stb       (stb),
    .panelRstN (panelRstN),
    .wrReq     (wrReq),
    .busy      (busy),
    .done      (done),
    .error     (error)
  );

  lcd_bringup_dp #(
    .CYC_PER_MS (CYC_PER_MS),
    .RST_MS     (RST_MS),
    .LONG_MS    (LONG_MS),
    .SHORT_MS   (SHORT_MS),
    .MODE_W     (MODE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .stb     (stb),
    .sts     (sts),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

endmodule

// File: rtl/lcd_bringup_chk.sv
module lcd_bringup_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [MODE_W-1:0] modeSel,
  input logic              panelRstN,
  input logic              wrReq,
  input logic [7:0]        wrAddr,
  input logic [7:0]        wrData,
  input logic              wrAck,
  input logic              busy,
  input logic              done,
  input logic              error
);

  // R1: flags low out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rstN) |-> !busy && !done && !error && !wrReq && panelRstN);

  // R2: unsupported code ends in error with nothing started
  assert_bad_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (int'(modeSel) >= 4)) |=> error && !busy && !wrReq && panelRstN);

  // R3: requests only during a run
  assert_req_in_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> busy);

  // R4: a start during a run does not abort it
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done) && !error);

  // R5: no request while the panel is held in reset
  assert_no_req_in_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    !panelRstN |-> !wrReq);

  // R6: pending write held until acknowledged
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> wrReq && $stable(wrAddr) && $stable(wrData));

  // R12: end flags never coexist with a run
  assert_flags_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done && !error);

  // R12: end flags hold while idle without start
  assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(done) && $stable(error));

  // R12: done only ends a run
  assert_done_after_run_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy));

endmodule

bind lcd_bringup_seq lcd_bringup_chk #(.MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .modeSel   (modeSel),
  .panelRstN (panelRstN),
  .wrReq     (wrReq),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .wrAck     (wrAck),
  .busy      (busy),
  .done      (done),
  .error     (error)
);

// File: tb/sim_lcd_bringup_seq.sv
module sim_lcd_bringup_seq;

  localparam int CYC   = 20;
  localparam int RSTMS = 1;
  localparam int LONG  = 10;
  localparam int SHORT = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       wrAck = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic       panelRstN, wrReq, busy, done, error;
  logic [7:0] wrAddr, wrData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lcd_bringup_seq #(
    .CYC_PER_MS (CYC),
    .RST_MS     (RSTMS),
    .LONG_MS    (LONG),
    .SHORT_MS   (SHORT),
    .MODE_W     (3)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeSel   (modeSel),
    .panelRstN (panelRstN),
    .wrReq     (wrReq),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrAck     (wrAck),
    .busy      (busy),
    .done      (done),
    .error     (error)
  );

  // expected timing bytes, leftmost byte belongs to register 0x14
  localparam logic [95:0] EXP_T0 = 96'h27_00_05_04_03_EF_00_05_00_0E_00_02;
  localparam logic [95:0] EXP_T1 = 96'h3B_00_01_00_05_0F_01_02_00_07_00_09;
  localparam logic [95:0] EXP_T2 = 96'h4F_05_0F_01_00_DF_01_0A_00_0E_00_01;
  localparam logic [95:0] EXP_T3 = 96'h63_03_03_02_00_DF_01_14_00_06_00_01;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expAddr(input int s);
    if (s == 0) return 'h88;
    if (s == 1) return 'h89;
    if (s == 2) return 'h10;
    if (s == 3) return 'h04;
    if (s == 16) return 'h8A;
    if (s == 17) return 'h8B;
    if (s == 18) return 'h01;
    return 'h14 + (s - 4);
  endfunction

  function automatic int expData(input int m, input int s);
    logic [95:0] t;
    if (s == 0) return (m >= 2) ? 'h0B : 'h0A;
    if (s == 1) return 'h02;
    if (s == 2) return 'h0C;
    if (s == 3) return (m == 0) ? 'h03 : (m == 1) ? 'h82 : (m == 2) ? 'h01 : 'h81;
    if (s == 16) return 'h81;
    if (s == 17) return 'hFF;
    if (s == 18) return 'h80;
    t = (m == 0) ? EXP_T0 : (m == 1) ? EXP_T1 : (m == 2) ? EXP_T2 : EXP_T3;
    return int'(t[95 - 8*(s-4) -: 8]);
  endfunction

  function automatic int expPause(input int s);
    if (s == 1 || s == 17 || s == 18) return LONG * CYC;
    if (s == 3) return SHORT * CYC;
    return 0;
  endfunction

  function automatic string dataTag(input int s);
    if (s == 3) return "R9 pixel clock";
    if (s >= 4 && s <= 15) return "R10 timing";
    return "R8 fixed value";
  endfunction

  // full run in one mode; ack delay dly; poke disturbs the run mid-way
  task automatic runSeq(input int mode, input int dly, input bit poke);
    int n;
    logic [7:0] ca, cd;
    @(negedge clk);
    modeSel = 3'(mode);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    chk(!done && !error, "R12 flags cleared by start", {done, error}, 0);
    n = 0;
    while (!panelRstN && n < 100000) begin
      n++;
      @(negedge clk);
    end
    chk(n == RSTMS * CYC, "R5 panel reset length", n, RSTMS * CYC);
    chk(wrReq == 1'b1, "R5 first request after reset", wrReq, 1);
    for (int s = 0; s < 19; s++) begin
      if (poke && s == 5) begin
        modeSel = 3'((mode + 1) % 4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4 start while busy ignored", busy, 1);
      end
      chk(wrReq == 1'b1, "R11 request present", wrReq, 1);
      ca = wrAddr;
      cd = wrData;
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(wrReq && wrAddr == ca && wrData == cd, "R6 hold until ack", {wrReq, wrAddr, wrData}, {1'b1, ca, cd});
      end
      chk(int'(ca) == expAddr(s), "R7 address order", ca, expAddr(s));
      chk(int'(cd) == expData(mode, s), dataTag(s), cd, expData(mode, s));
      wrAck = 1'b1;
      @(negedge clk);
      wrAck = 1'b0;
      n = 0;
      while (!wrReq && !done && n < 100000) begin
        n++;
        @(negedge clk);
      end
      if (s == 18) begin
        chk(n == expPause(s), "R12 final wait", n, expPause(s));
        chk(done && !busy && !error, "R12 done at end", {done, busy, error}, 3'b100);
      end else begin
        chk(n == expPause(s), "R11 gap after write", n, expPause(s));
      end
    end
    repeat (3) @(negedge clk);
    chk(done && !wrReq && !busy, "R7 no write after the 19th", {done, wrReq, busy}, 3'b100);
  endtask

  task automatic runBad(input int mode);
    @(negedge clk);
    modeSel = 3'(mode);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(error && !busy && !done, "R2 error on unsupported mode", {error, busy, done}, 3'b100);
    for (int i = 0; i < 2 * CYC; i++) begin
      chk(!wrReq && panelRstN, "R2 nothing issued", {wrReq, panelRstN}, 2'b01);
      @(negedge clk);
    end
    chk(error == 1'b1, "R12 error held", error, 1);
  endtask

  task automatic checkReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error, "R1 flags in reset", {busy, done, error}, 0);
    chk(!wrReq && panelRstN, "R1 outputs in reset", {wrReq, panelRstN}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !wrReq && panelRstN, "R1 after reset", {busy, done, error, wrReq, panelRstN}, 1);
  endtask

  initial begin
    checkReset();
    runSeq(0, 0, 1'b0);
    runSeq(1, 2, 1'b0);
    runSeq(2, 1, 1'b0);
    runSeq(3, 3, 1'b1);
    runBad(4);
    runBad(7);
    runSeq(1, 0, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule